// File: doc/BRIEF.md
# Radix-4 Booth Partial Product Generator

This block takes a signed multiplicand and a signed multiplier, recodes the multiplier into radix-4 signed digits and forms every partial product in one pass. Each partial product is aligned to its weight and sign-extended to the full product width. The block is meant to feed a separate summation tree, which is not part of this design.

Negative digits are formed only by bitwise inversion of the selected magnitude. The block does not add the missing +1. It raises one correction flag per partial product, and the downstream adder applies that flag as a carry-in at the product's weight.

A strobe loads the results, together with the flags, into output registers. The registers hold their contents until the next strobe.

Top module: `booth_pp_gen`

## Requirements
- R1: While rst_n is low, out_valid, every bit of pp_flat and every bit of corr are 0, regardless of the clock.
- R2: When in_valid is high at a rising clock edge, out_valid is high after that edge and the outputs reflect the operands sampled at that edge. When in_valid is low at a rising clock edge, out_valid is low after that edge.
- R3: A rising edge with in_valid low leaves pp_flat and corr unchanged, whatever the operands are.
- R4: Digit i (i = 0 .. P-1, with P = ceil(N/2)) is taken from the three multiplier bits at positions 2i+1, 2i and 2i-1. Position -1 reads as 0, and positions above N-1 repeat the sign bit mplier[N-1].
- R5: With the group written as top, middle, bottom, the digit value is middle + bottom - 2*top. This gives 000->0, 001->+1, 010->+1, 011->+2, 100->-2, 101->-1, 110->-1, 111->0.
- R6: Slot i of pp_flat is bits [i*2N +: 2N]. Let M be |digit| times the multiplicand, sign-extended to 2N bits. For a positive digit the slot holds M shifted left by 2i. For a negative digit it holds the bitwise inverse of M, shifted left by 2i. Results are kept modulo 2^(2N).
- R7: corr[i] is 1 exactly when digit i is negative (-1 or -2).
- R8: The sum of all slots, plus corr[i] * 2^(2i) over all i, equals the signed product of the two operands modulo 2^(2N).
- R9: A zero digit (group 000 or 111) makes slot i all zeros and corr[i] 0, for any multiplicand.
- R10: Bits below position 2i of slot i are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Load strobe for the operands |
| mcand | input | N | Signed multiplicand |
| mplier | input | N | Signed multiplier |
| out_valid | output | 1 | High for one cycle after each load |
| pp_flat | output | P*2N | Aligned partial products, slot i at [i*2N +: 2N] |
| corr | output | P | Per-slot +1 correction flags, weight 2^(2i) |

## Verification
A fixed 8-by-8 arithmetic check that multiplies 107 by 52 proves the digit sequence -1, -1, -1, +2. It also confirms that the slots plus the correction flags sum to 5564.

The other directed operands each target one part of the logic:
- An all-ones multiplier yields only 111 groups above slot 0, which exercises the zero-digit path.
- Alternating bit patterns and the most negative values reach the -2 and +2 paths with sign extension at the top of the range.
- A zero multiplicand separates inverted-zero rows from true zero rows.

Seeded random operands then compare every slot, flag and sum against models built from the digit rule. Idle cycles with changed operands show that the outputs hold.

// File: rtl/booth_pkg.sv
package booth_pkg;

  // One-hot recoded digit controls
  typedef struct packed {
    logic nil;
    logic pos1;
    logic pos2;
    logic neg1;
    logic neg2;
  } booth_ctl_t;

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_pkg::*;
(
  input  logic [2:0] grp,
  output booth_ctl_t ctl
);

  always_comb begin
    ctl = '0;
    unique case (grp)
      3'b000, 3'b111: ctl.nil  = 1'b1;
      3'b001, 3'b010: ctl.pos1 = 1'b1;
      3'b011:         ctl.pos2 = 1'b1;
      3'b100:         ctl.neg2 = 1'b1;
      default:        ctl.neg1 = 1'b1;  // 101, 110
    endcase
  end

endmodule

// File: rtl/booth_row.sv
module booth_row
  import booth_pkg::*;
#(
  parameter int N     = 8,
  parameter int SHIFT = 0,
  localparam int W    = 2 * N
) (
  input  logic [N-1:0] mcand,
  input  booth_ctl_t   ctl,
  output logic [W-1:0] pp,
  output logic         corr
);

  logic [N:0]   single_v;
  logic [N:0]   double_v;
  logic [N:0]   sel_v;
  logic [N:0]   body_v;
  logic         invert;
  logic [W-1:0] ext_v;

  assign single_v = {mcand[N-1], mcand};
  assign double_v = {mcand, 1'b0};
  assign invert   = ctl.neg1 | ctl.neg2;

  always_comb begin
    sel_v = ({(N+1){ctl.pos1 | ctl.neg1}} & single_v) |
            ({(N+1){ctl.pos2 | ctl.neg2}} & double_v);
    if (ctl.nil) begin
      body_v = '0;
    end else if (invert) begin
      body_v = ~sel_v;
    end else begin
      body_v = sel_v;
    end
  end

  assign ext_v = {{(W-N-1){body_v[N]}}, body_v};
  assign pp    = ext_v << SHIFT;
  assign corr  = invert;

endmodule

// File: rtl/booth_pp_gen.sv
module booth_pp_gen
  import booth_pkg::*;
#(
  parameter int N    = 8,
  localparam int W   = 2 * N,
  localparam int P   = (N + 1) / 2,
  localparam int EXW = 2 * P + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [N-1:0] mcand,
  input  logic [N-1:0] mplier,
  output logic         out_valid,
  output logic [P*W-1:0] pp_flat,
  output logic [P-1:0] corr
);

  logic [N:0]     y_shift;
  logic [EXW-1:0] y_ext;
  logic [P*W-1:0] pp_nxt;
  logic [P-1:0]   corr_nxt;
  logic [P*W-1:0] pp_q;
  logic [P-1:0]   corr_q;
  logic           vld_q;

  // Multiplier with a zero below the LSB, sign-extended on top
  assign y_shift = {mplier, 1'b0};
  assign y_ext   = EXW'($signed(y_shift));

  for (genvar i = 0; i < P; i++) begin : g_row
    booth_ctl_t ctl;

    booth_recoder u_rec (
      .grp (y_ext[2*i +: 3]),
      .ctl (ctl)
    );

    booth_row #(
      .N     (N),
      .SHIFT (2 * i)
    ) u_row (
      .mcand (mcand),
      .ctl   (ctl),
      .pp    (pp_nxt[i*W +: W]),
      .corr  (corr_nxt[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pp_q   <= '0;
      corr_q <= '0;
    end else if (in_valid) begin
      pp_q   <= pp_nxt;
      corr_q <= corr_nxt;
    end
  end

  assign out_valid = vld_q;
  assign pp_flat   = pp_q;
  assign corr      = corr_q;

endmodule

// File: rtl/booth_pp_gen_chk.sv
module booth_pp_gen_chk #(
  parameter int N    = 8,
  localparam int W   = 2 * N,
  localparam int P   = (N + 1) / 2,
  localparam int EXW = 2 * P + 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [N-1:0]   mcand,
  input logic [N-1:0]   mplier,
  input logic           out_valid,
  input logic [P*W-1:0] pp_flat,
  input logic [P-1:0]   corr
);

  logic [N:0]     ys;
  logic [EXW-1:0] yx;
  assign ys = {mplier, 1'b0};
  assign yx = EXW'($signed(ys));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(pp_flat) && $stable(corr)));

  a_r9_zero_mplier: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mplier == '0) |=> (pp_flat == '0 && corr == '0));

  for (genvar i = 0; i < P; i++) begin : g_chk
    a_r7_corr_sign: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (corr[i] == $past(yx[2*i+2] & ~(yx[2*i+1] & yx[2*i]))));

    if (i > 0) begin : g_low
      a_r10_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        pp_flat[i*W +: 2*i] == '0);
    end
  end

  // R1: no capture leaves the outputs nonzero while reset is held
  always @(negedge clk) begin
    if (!rst_n) begin
      a_r1_reset_clear: assert (out_valid == 1'b0 && pp_flat == '0 && corr == '0);
    end
  end

endmodule

bind booth_pp_gen booth_pp_gen_chk #(.N(N)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .mcand     (mcand),
  .mplier    (mplier),
  .out_valid (out_valid),
  .pp_flat   (pp_flat),
  .corr      (corr)
);

// File: tb/test_booth_pp_gen.sv
module test_booth_pp_gen;

  localparam int N = 8;
  localparam int W = 2 * N;
  localparam int P = (N + 1) / 2;

  logic           clk;
  logic           rst_n;
  logic           in_valid;
  logic [N-1:0]   mcand;
  logic [N-1:0]   mplier;
  logic           out_valid;
  logic [P*W-1:0] pp_flat;
  logic [P-1:0]   corr;

  int tests;
  int fails;
  bit done;

  booth_pp_gen #(.N(N)) i_booth_pp_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mcand     (mcand),
    .mplier    (mplier),
    .out_valid (out_valid),
    .pp_flat   (pp_flat),
    .corr      (corr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  // R4/R5: digit from group (top, mid, bot) = mid + bot - 2*top
  function automatic int digit_of(logic [N-1:0] y, int i);
    int b0, b1, b2;
    b0 = (2*i - 1 < 0) ? 0 : int'(y[2*i-1]);
    b1 = (2*i >= N) ? int'(y[N-1]) : int'(y[2*i]);
    b2 = (2*i + 1 >= N) ? int'(y[N-1]) : int'(y[2*i+1]);
    return b1 + b0 - 2 * b2;
  endfunction

  // R6: expected slot contents
  function automatic logic [W-1:0] exp_pp(logic [N-1:0] x, logic [N-1:0] y, int i);
    int d;
    logic [W-1:0] xs;
    logic [W-1:0] v;
    d  = digit_of(y, i);
    xs = {{(W-N){x[N-1]}}, x};
    if (d == 0) return '0;
    v = (d == 2 || d == -2) ? (xs << 1) : xs;
    if (d < 0) v = ~v;
    return v << (2 * i);
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [N-1:0] x, logic [N-1:0] y);
    logic [W-1:0] sum;
    logic [W-1:0] prod;
    @(negedge clk);
    in_valid = 1'b1;
    mcand    = x;
    mplier   = y;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 out_valid", W'(out_valid), W'(1));
    sum = '0;
    for (int i = 0; i < P; i++) begin
      check("R6 slot", pp_flat[i*W +: W], exp_pp(x, y, i));
      check("R7 corr", W'(corr[i]), W'(digit_of(y, i) < 0));
      check("R10 low bits", W'(pp_flat[i*W +: W] & ((W'(1) << (2*i)) - W'(1))), '0);
      if (digit_of(y, i) == 0)
        check("R9 zero digit", pp_flat[i*W +: W] | W'(corr[i]), '0);
      sum = sum + pp_flat[i*W +: W] + (W'(corr[i]) << (2*i));
    end
    prod = W'($signed({{(W-N){x[N-1]}}, x}) * $signed({{(W-N){y[N-1]}}, y}));
    check("R8 sum", sum, prod);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [P*W-1:0] pp_hold;
    logic [P-1:0]   corr_hold;
    int unsigned    seed;
    tests    = 0;
    fails    = 0;
    done     = 1'b0;
    seed     = 32'd20240611;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    mcand    = '0;
    mplier   = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset valid", W'(out_valid), '0);
    check("R1 reset pp", W'(pp_flat != '0), '0);
    check("R1 reset corr", W'(corr), '0);
    rst_n = 1'b1;

    // R5 / R8 arithmetic check: 107 x 52, digits -1,-1,-1,+2
    apply(8'd52, 8'd107);
    check("R5 digit0", W'(digit_of(8'd107, 0) == -1), W'(1));
    check("R5 digit3", W'(digit_of(8'd107, 3) == 2), W'(1));
    check("R8 107x52", W'(5564), W'(52 * 107));

    apply(8'h80, 8'h80);
    apply(8'h7F, 8'h80);
    apply(8'h80, 8'h7F);
    apply(8'h00, 8'hAA);   // R9: inverted-zero rows versus true zero rows
    apply(8'h5C, 8'hFF);   // R9: 111 groups above slot 0
    apply(8'h93, 8'h55);
    apply(8'h93, 8'hAA);
    apply(8'h01, 8'h00);

    // R3: idle cycles with new operands leave outputs unchanged
    pp_hold   = pp_flat;
    corr_hold = corr;
    @(negedge clk);
    mcand  = 8'h3C;
    mplier = 8'hC3;
    repeat (2) @(negedge clk);
    check("R3 hold pp", W'(pp_flat != pp_hold), '0);
    check("R3 hold corr", W'(corr ^ corr_hold), '0);
    check("R2 valid low", W'(out_valid), '0);

    for (int k = 0; k < 300; k++) begin
      logic [N-1:0] rx;
      logic [N-1:0] ry;
      rx = N'($urandom(seed));
      ry = N'($urandom());
      apply(rx, ry);
    end

    // R1: asynchronous reset clears the loaded outputs
    apply(8'h71, 8'h9B);
    #1 rst_n = 1'b0;
    #1;
    check("R1 async pp", W'(pp_flat != '0), '0);
    check("R1 async corr", W'(corr), '0);
    check("R1 async valid", W'(out_valid), '0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule